// File: doc/BRIEF.md
# Stepper Bridge Fault Supervisor

This block is a synchronous supervisor that sits between the control pins of a stepper H-bridge driver and its power stage. It decides when the bridge may conduct, whether the active-low fault output is driven, and whether step pulses may reach the indexer. It takes in a sleep request, a driver reset, three analog fault flags (per-FET current limit, over-temperature, supply undervoltage) and the step input. All of these inputs are asynchronous. Each one passes through a two-flop synchroniser before any logic uses it.

The three fault classes recover in different ways:

- **Overcurrent** is latched. It is only set after the current-limit flag has been held for longer than a programmable number of cycles. Only the driver reset or an undervoltage event clears it.
- **Over-temperature** clears by itself when its flag drops.
- **Undervoltage** wipes all internal state.

Leaving sleep starts a settling window of about one microsecond-scaled interval (`SETTLE_US` microseconds at `CLK_HZ`). Step edges that arrive inside this window are dropped. Undervoltage recovery restarts the same window.

Top module: `mdrv_fault_sup`

## Requirements
- R1: While the synchronised sleep input is low and no undervoltage is present, `bridge_en_o`=0, `fault_no`=1 and `fault_code_o`=0. Step edges are dropped, the current-limit flag is not counted, and a low driver reset leaves a latched overcurrent in place.
- R2: After sleep is released, no step edge is passed until `SETTLE_CYC = CLK_HZ/1_000_000*SETTLE_US` cycles have elapsed. After that, edges are passed.
- R3: The overcurrent latch sets only when the synchronised current-limit flag has been high for more than `ocp_time_i` consecutive cycles. A pulse of exactly `ocp_time_i` cycles, or fewer, leaves no trace.
- R4: While overcurrent is latched (awake, no undervoltage), `bridge_en_o`=0, `fault_no`=0 and `fault_code_o`=1.
- R5: A latched overcurrent persists after the current-limit flag clears. It is cleared by `drv_rst_ni` low while awake, or by undervoltage.
- R6: An over-temperature flag with no latched overcurrent gives `bridge_en_o`=0, `fault_no`=0 and `fault_code_o`=2.
- R7: When the over-temperature flag clears with no other fault, `bridge_en_o`=1, `fault_no`=1 and `fault_code_o`=0 again, without any reset.
- R8: Undervoltage gives `bridge_en_o`=0, `fault_no`=0 and `fault_code_o`=3. It clears the overcurrent latch and restarts the settling window.
- R9: Fault priority is undervoltage, then sleep, then overcurrent, then over-temperature. The code reports the highest active condition: 0 none, 1 overcurrent, 2 thermal, 3 undervoltage.
- R10: Each rising step edge that is seen while the bridge is enabled and settling is complete produces exactly one one-cycle `step_o` pulse. Edges that arrive while blocked are dropped, not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low chip reset |
| sleep_ni | input | 1 | Active-low sleep request |
| drv_rst_ni | input | 1 | Active-low driver reset, clears latched overcurrent |
| ilim_i | input | 1 | Analog current-limit comparator flag |
| otemp_i | input | 1 | Over-temperature flag |
| uvlo_i | input | 1 | Supply undervoltage flag |
| step_i | input | 1 | Step pulse input |
| ocp_time_i | input | QUAL_W | Overcurrent qualification time in cycles |
| bridge_en_o | output | 1 | Bridge FET enable |
| fault_no | output | 1 | Active-low fault indication |
| fault_code_o | output | 2 | Active fault: 0 none, 1 overcurrent, 2 thermal, 3 undervoltage |
| step_o | output | 1 | Qualified step pulse |

## Verification
The bench targets the following corner cases:

- **Qualification boundary.** It drives current-limit pulses of exactly `ocp_time_i` and `ocp_time_i+1` cycles. An off-by-one counter would latch on the shorter pulse or miss the longer one.
- **Reset while asleep.** It asserts the driver reset during sleep. A design that honoured it would lose the latch.
- **Undervoltage with a latched overcurrent.** It raises undervoltage while overcurrent is latched. A design that kept the latch would return with the bridge still off.
- **Settling window.** It issues steps right after wake and right after undervoltage recovery. A design that queued those edges, or skipped the window, would emit extra step pulses.

Random sequences of fault, sleep and step events are checked against a priority model of the outputs.

// File: rtl/mdrv_pkg.sv
package mdrv_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_OCP   = 2'd1,
    FLT_THERM = 2'd2,
    FLT_UV    = 2'd3
  } flt_code_e;

  // synchroniser lane positions
  localparam int unsigned L_ILIM  = 0;
  localparam int unsigned L_OT    = 1;
  localparam int unsigned L_UV    = 2;
  localparam int unsigned L_SLEEP = 3;
  localparam int unsigned L_DRST  = 4;
  localparam int unsigned L_STEP  = 5;
  localparam int unsigned LANES   = 6;
endpackage

// File: rtl/mdrv_sync.sv
module mdrv_sync #(
  parameter int unsigned W         = 1,
  parameter logic [W-1:0] RST_VAL  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/mdrv_ocp_qual.sv
module mdrv_ocp_qual #(
  parameter int unsigned QUAL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              hold_i,
  input  logic              ilim_i,
  input  logic [QUAL_W-1:0] qual_i,
  output logic              lat_o
);
  logic [QUAL_W-1:0] cnt_q;
  logic              lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (hold_i || lat_q || !ilim_i) begin
      cnt_q <= '0;
    end else if (cnt_q == qual_i) begin
      // flag held for qual_i+1 samples: strictly longer than qual_i
      lat_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/mdrv_wake_timer.sv
module mdrv_wake_timer #(
  parameter int unsigned CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic ready_o
);
  localparam int unsigned CW   = (CYC < 2) ? 1 : $clog2(CYC + 1);
  localparam int unsigned LAST = (CYC < 1) ? 0 : CYC - 1;

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == CW'(LAST)) rdy_q <= 1'b1;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/mdrv_fault_sup.sv
module mdrv_fault_sup #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SETTLE_US = 1000,
  parameter int unsigned QUAL_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_ni,
  input  logic              drv_rst_ni,
  input  logic              ilim_i,
  input  logic              otemp_i,
  input  logic              uvlo_i,
  input  logic              step_i,
  input  logic [QUAL_W-1:0] ocp_time_i,
  output logic              bridge_en_o,
  output logic              fault_no,
  output logic [1:0]        fault_code_o,
  output logic              step_o
);
  import mdrv_pkg::*;

  localparam int unsigned SETTLE_CYC = CLK_HZ / 1_000_000 * SETTLE_US;
  localparam logic [LANES-1:0] SYNC_RST = LANES'(1) << L_DRST;

  logic [LANES-1:0] raw, syn;
  logic ilim_s, ot_s, uv_s, sleep_s, drv_rst_s, step_s;
  logic ocp_lat, ready;
  logic step_d, step_q;
  flt_code_e code;

  always_comb begin
    raw          = '0;
    raw[L_ILIM]  = ilim_i;
    raw[L_OT]    = otemp_i;
    raw[L_UV]    = uvlo_i;
    raw[L_SLEEP] = sleep_ni;
    raw[L_DRST]  = drv_rst_ni;
    raw[L_STEP]  = step_i;
  end

  mdrv_sync #(.W(LANES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign ilim_s    = syn[L_ILIM];
  assign ot_s      = syn[L_OT];
  assign uv_s      = syn[L_UV];
  assign sleep_s   = syn[L_SLEEP];
  assign drv_rst_s = syn[L_DRST];
  assign step_s    = syn[L_STEP];

  // driver reset is honoured only while awake
  mdrv_ocp_qual #(.QUAL_W(QUAL_W)) u_ocp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (uv_s | (sleep_s & ~drv_rst_s)),
    .hold_i(~sleep_s),
    .ilim_i(ilim_s),
    .qual_i(ocp_time_i),
    .lat_o (ocp_lat)
  );

  mdrv_wake_timer #(.CYC(SETTLE_CYC)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (sleep_s & ~uv_s),
    .ready_o(ready)
  );

  always_comb begin
    if (uv_s)          code = FLT_UV;
    else if (!sleep_s) code = FLT_NONE;
    else if (ocp_lat)  code = FLT_OCP;
    else if (ot_s)     code = FLT_THERM;
    else               code = FLT_NONE;
  end

  assign bridge_en_o  = sleep_s & ~uv_s & ~ocp_lat & ~ot_s;
  assign fault_no     = ~(uv_s | (sleep_s & (ocp_lat | ot_s)));
  assign fault_code_o = code;

  // edges seen while blocked are consumed, never queued
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_d <= 1'b0;
      step_q <= 1'b0;
    end else begin
      step_d <= step_s;
      step_q <= step_s & ~step_d & ready & bridge_en_o;
    end
  end

  assign step_o = step_q;
endmodule

// File: rtl/mdrv_fault_sup_chk.sv
module mdrv_fault_sup_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       uv_s,
  input logic       sleep_s,
  input logic       ilim_s,
  input logic       ot_s,
  input logic       drv_rst_s,
  input logic       ocp_lat,
  input logic       ready,
  input logic       bridge_en_o,
  input logic       fault_no,
  input logic [1:0] fault_code_o,
  input logic       step_o
);
  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_s && !uv_s) |-> (!bridge_en_o && fault_no && fault_code_o == 2'd0)); // R1
  AST_STEP_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> ($past(ready) && $past(bridge_en_o))); // R2
  AST_OCP_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ocp_lat) |-> $past(ilim_s)); // R3
  AST_OCP_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocp_lat && sleep_s && !uv_s) |-> (!bridge_en_o && !fault_no && fault_code_o == 2'd1)); // R4
  AST_OCP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocp_lat && !uv_s && (drv_rst_s || !sleep_s)) |=> ocp_lat); // R5
  AST_THERM_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_s && !ocp_lat && sleep_s && !uv_s) |-> (!bridge_en_o && !fault_no && fault_code_o == 2'd2)); // R6
  AST_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_s && !uv_s && !ocp_lat && !ot_s) |-> (bridge_en_o && fault_no && fault_code_o == 2'd0)); // R7
  AST_UV_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_s |-> (!bridge_en_o && !fault_no && fault_code_o == 2'd3)); // R8
  AST_UV_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(uv_s) |-> (!ocp_lat && !ready)); // R8
  AST_STEP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o); // R10
endmodule

bind mdrv_fault_sup mdrv_fault_sup_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .uv_s        (uv_s),
  .sleep_s     (sleep_s),
  .ilim_s      (ilim_s),
  .ot_s        (ot_s),
  .drv_rst_s   (drv_rst_s),
  .ocp_lat     (ocp_lat),
  .ready       (ready),
  .bridge_en_o (bridge_en_o),
  .fault_no    (fault_no),
  .fault_code_o(fault_code_o),
  .step_o      (step_o)
);

// File: tb/tb_mdrv_fault_sup.sv
`timescale 1ns/1ps
module tb_mdrv_fault_sup;
  localparam int unsigned CLK_HZ = 50_000_000;
  localparam int unsigned SET_US = 1;
  localparam int unsigned SETC   = CLK_HZ / 1_000_000 * SET_US;
  localparam int unsigned QW     = 8;
  localparam int unsigned QT     = 4;

  logic clk = 0, rst_n = 0;
  logic sleep_n = 0, drst_n = 1, ilim = 0, ot = 0, uv = 0, step = 0;
  logic [QW-1:0] qtime = QW'(QT);
  logic en, fn, so;
  logic [1:0] code;

  int n_chk = 0, n_fail = 0, steps = 0;
  bit done = 0;
  bit m_sleep = 1, m_ocp = 0, m_ot = 0;

  always #10 clk = ~clk;
  always @(posedge clk) if (so) steps++;

  mdrv_fault_sup #(.CLK_HZ(CLK_HZ), .SETTLE_US(SET_US), .QUAL_W(QW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_ni(sleep_n), .drv_rst_ni(drst_n),
    .ilim_i(ilim), .otemp_i(ot), .uvlo_i(uv), .step_i(step),
    .ocp_time_i(qtime), .bridge_en_o(en), .fault_no(fn),
    .fault_code_o(code), .step_o(so)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code();
    if (!m_sleep) return 0;
    if (m_ocp)    return 1;
    if (m_ot)     return 2;
    return 0;
  endfunction

  task automatic chk_state(string req);
    chk({req, " en"},   en,   int'(m_sleep && !m_ocp && !m_ot));
    chk({req, " fn"},   fn,   int'(!(m_sleep && (m_ocp || m_ot))));
    chk({req, " code"}, code, exp_code());
  endtask

  task automatic pulses(int n, output int got);
    int s0 = steps;
    for (int i = 0; i < n; i++) begin
      step = 1; tick(2); step = 0; tick(2);
    end
    tick(4);
    got = steps - s0;
  endtask

  task automatic burst(int len);
    ilim = 1; tick(len); ilim = 0; tick(5);
    if (m_sleep && len > QT) m_ocp = 1;
  endtask

  task automatic set_sleep(bit awake);
    sleep_n = awake; m_sleep = awake;
    tick(awake ? SETC + 8 : 5);
  endtask

  task automatic drv_reset();
    drst_n = 0; tick(3); drst_n = 1; tick(4);
    if (m_sleep) m_ocp = 0;
  endtask

  task automatic uv_pulse();
    uv = 1; tick(5);
    chk("R8 uv en", en, 0); chk("R8 uv fn", fn, 0); chk("R8 uv code", code, 3);
    uv = 0; m_ocp = 0; tick(SETC + 8);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int got;
    m_sleep = 0;
    tick(3); rst_n = 1; tick(4);
    chk_state("R1 reset asleep");

    // R2: steps inside settling window are dropped
    sleep_n = 1; m_sleep = 1;
    tick(2);
    pulses(2, got); chk("R2 early steps dropped", got, 0);
    tick(SETC + 4);
    pulses(3, got); chk("R10 steps after settle", got, 3);
    chk_state("R7 running");

    // R3 boundary
    burst(QT);     chk_state("R3 pulse of exactly qual time");
    burst(QT + 1); chk_state("R3 pulse above qual time");
    chk("R4 ocp code", code, 1);
    pulses(2, got); chk("R10 steps blocked in ocp", got, 0);
    tick(10); chk_state("R5 latch after flag cleared");

    // R1: reset in sleep ignored
    set_sleep(0);
    drv_reset(); // model keeps m_ocp since asleep
    pulses(1, got); chk("R1 step in sleep", got, 0);
    burst(QT + 3);
    set_sleep(1);
    chk("R1 latch survives reset in sleep", code, 1);
    drv_reset(); chk_state("R5 cleared by reset");

    // thermal
    ot = 1; m_ot = 1; tick(4); chk_state("R6 thermal");
    burst(QT + 1); chk("R9 ocp over thermal", code, 1);
    drv_reset(); chk_state("R6 thermal after reset");
    ot = 0; m_ot = 0; tick(4); chk_state("R7 auto recover");

    // R8 with latched ocp, then settling restart
    burst(QT + 2);
    ot = 1; m_ot = 1;
    uv = 1; tick(5);
    chk("R9 uv over all", code, 3);
    uv = 0; m_ocp = 0; tick(3);
    pulses(1, got); chk("R8 step after uv dropped", got, 0);
    tick(SETC);
    chk_state("R8 ocp cleared by uv");
    ot = 0; m_ot = 0; tick(4);
    pulses(2, got); chk("R8 steps after resettle", got, 2);
    set_sleep(0); ot = 1; m_ot = 1; tick(4);
    chk_state("R9 sleep over thermal");
    ot = 0; m_ot = 0; set_sleep(1);

    // constrained random
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 6);
      case (op)
        0: set_sleep(!m_sleep);
        1: begin ot = !ot; m_ot = ot; tick(4); end
        2: burst($urandom_range(1, 7));
        3: drv_reset();
        4: uv_pulse();
        5: begin
             pulses($urandom_range(1, 3), got);
             chk("R10 random steps zero-or-all", int'(got == 0 || (m_sleep && !m_ocp && !m_ot)), 1);
             if (!(m_sleep && !m_ocp && !m_ot)) chk("R10 blocked random steps", got, 0);
           end
        default: tick($urandom_range(1, 6));
      endcase
      chk_state("R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule